// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer with Power-Up and Refresh

This block drives the command pins of a four-bank single-data-rate SDRAM. Out of reset it holds clock enable and the data mask high and issues only no-operation commands for the power-up pause. It then precharges all banks, programs the mode register and issues the initial auto refreshes. After that it enters an idle state, where it issues an auto refresh at a fixed interval and serves single user accesses.

A user access is taken through a valid/ready handshake. Each access is carried out as three commands: open the row, then one read or write with burst length one, then close the row with a precharge. An acknowledge pulse marks the cycle in which the column command is on the pins. All spacing rules are module parameters in picoseconds. Each is turned into a clock count at elaboration by rounding up, except the refresh interval, which is rounded down. A refresh that has come due is served before a waiting request, and only from idle, once any open row has been closed.

Pin encoding of {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, MODE SET 0000. All pins are registered, so a decision appears on the pins one clock later.

Top module: `sdr_init_refresh_ctl`

## Requirements
- R1: In reset and during the power-up pause, the pins show NOP (0111), sd_cke and sd_dqm are 1, and req_ready is 0; sd_cke stays 1 at all times.
- R2: The first non-NOP command is PRECHARGE with sd_addr[10]=1, appearing exactly ceil(T_INIT_PS/CLK_PS) cycles after reset is released.
- R3: MODE SET follows exactly ceil(T_RP_PS/CLK_PS) cycles later, with sd_ba=0 and a mode word that holds the CAS latency in A6:A4 (2 = 010, 3 = 011), sequential wrap in A3 (0), burst length one in A2:A0 (000), and 0 in all other bits.
- R4: Only NOPs follow MODE SET for TMRD_CYC-1 cycles; the first AUTO REFRESH comes exactly TMRD_CYC cycles after it.
- R5: INIT_REFRESHES auto refreshes are issued exactly ceil(T_RC_PS/CLK_PS) cycles apart. req_ready stays 0 until they are done, and afterwards sd_dqm is 0.
- R6: An accepted request produces ACTIVE with the request's bank and row. READ (write=0) or WRITE (write=1) follows exactly ceil(T_RCD_PS/CLK_PS) cycles later, with the same bank, the column in A8:A0 and A10=0.
- R7: req_ack is 1 exactly in the cycles in which READ or WRITE is on the pins.
- R8: PRECHARGE with A10=0 and the same bank follows the column command after max(1, tRAS-tRCD) cycles for a read and max(TDPL_CYC, tRAS-tRCD) cycles for a write, all counts in clocks.
- R9: No ACTIVE, MODE SET or AUTO REFRESH appears less than tRP cycles after a PRECHARGE.
- R10: Nothing but NOP appears less than tRC cycles after an AUTO REFRESH. When idle, auto refreshes come exactly floor(T_REFI_PS/CLK_PS) cycles apart.
- R11: A due refresh has priority over a waiting request. No ACTIVE appears from the due cycle until that refresh is issued, and the refresh appears at the later of its due cycle and the end of the preceding tRP or tRC wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A user access is offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_ready | output | 1 | Access accepted on a clock edge where valid and ready are both 1 |
| req_ack | output | 1 | Pulses with the READ or WRITE command on the pins |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed address, A10 as precharge-all or auto-precharge flag |
| sd_dqm | output | 1 | Data mask |

## Verification
The hardest case to reach from the ports is a refresh coming due while a request is already waiting, part-way through another access. The bench first lets the block sit idle for three refresh intervals, which fixes the phase of the free-running refresh timer. It then presents sixteen requests back to back, with the refresh interval set short enough that every refresh lands in the middle of traffic. From the phase and the exact access length, it works out for each refresh when it must appear and checks that no row was opened in between.

// File: rtl/sdr_ctl_pkg.sv
package sdr_ctl_pkg;

    typedef enum logic [3:0] {
        CMD_MODESET = 4'b0000,
        CMD_REFRESH = 4'b0001,
        CMD_PRECHG  = 4'b0010,
        CMD_ACTIVE  = 4'b0011,
        CMD_WRITE   = 4'b0100,
        CMD_READ    = 4'b0101,
        CMD_BSTOP   = 4'b0110,
        CMD_NOP     = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_INIT_MODE,
        ST_INIT_REF,
        ST_IDLE,
        ST_COLUMN,
        ST_CLOSE
    } seq_state_e;

    function automatic int ceil_cycles(input int ps, input int clk_ps);
        int c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_cmd_pins.sv
module sdr_cmd_pins
    import sdr_ctl_pkg::*;
(
    input  sdr_cmd_e cmd,
    output logic     cs_n,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n
);
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = 4'(cmd);
    end
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int REFI_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic served,
    output logic pending
);
    localparam int TW = $clog2(REFI_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (served) d.pend = 1'b0;
        if (enable) begin
            if (q.cnt == TW'(REFI_CYC - 1)) begin
                d.cnt  = '0;
                d.pend = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.pend;
endmodule

// File: rtl/sdr_init_refresh_ctl.sv
module sdr_init_refresh_ctl
    import sdr_ctl_pkg::*;
#(
    parameter int CLK_PS         = 4000,
    parameter int T_INIT_PS      = 200_000_000,
    parameter int T_RP_PS        = 20_000,
    parameter int T_RCD_PS       = 20_000,
    parameter int T_RAS_PS       = 45_000,
    parameter int T_RC_PS        = 67_500,
    parameter int T_REFI_PS      = 15_600_000,
    parameter int TMRD_CYC       = 2,
    parameter int TDPL_CYC       = 2,
    parameter int CAS_LATENCY    = 3,
    parameter int INIT_REFRESHES = 2,
    parameter int BANK_W         = 2,
    parameter int ROW_W          = 12,
    parameter int COL_W          = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    output logic              req_ack,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              sd_dqm
);
    localparam int INIT_CYC = ceil_cycles(T_INIT_PS, CLK_PS);
    localparam int TRP_CYC  = ceil_cycles(T_RP_PS, CLK_PS);
    localparam int TRCD_CYC = ceil_cycles(T_RCD_PS, CLK_PS);
    localparam int TRAS_CYC = ceil_cycles(T_RAS_PS, CLK_PS);
    localparam int TRC_CYC  = ceil_cycles(T_RC_PS, CLK_PS);
    localparam int REFI_CYC = max_int(2, T_REFI_PS / CLK_PS);
    localparam int RD_GAP   = max_int(1, TRAS_CYC - TRCD_CYC);
    localparam int WR_GAP   = max_int(TDPL_CYC, TRAS_CYC - TRCD_CYC);
    localparam int MAX_WAIT = max_int(max_int(INIT_CYC, TRC_CYC),
                              max_int(max_int(TRP_CYC, TRCD_CYC),
                              max_int(max_int(RD_GAP, WR_GAP), TMRD_CYC)));
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int RFW      = $clog2(INIT_REFRESHES + 1);
    // CAS latency in A6:A4, sequential wrap (A3=0), burst length one (A2:A0=000)
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LATENCY << 4);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [RFW-1:0]    refs_left;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              wr;
        sdr_cmd_e          cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  addr;
        logic              dqm;
        logic              ack;
        logic              init_done;
    } seq_t;

    seq_t q, d;
    logic ref_pending;
    logic ref_served;

    sdr_refresh_timer #(.REFI_CYC(REFI_CYC)) u_refi (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (q.init_done),
        .served  (ref_served),
        .pending (ref_pending)
    );

    always_comb begin
        d          = q;
        d.cmd      = CMD_NOP;
        d.ba       = '0;
        d.addr     = '0;
        d.ack      = 1'b0;
        ref_served = 1'b0;
        if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else begin
            case (q.st)
                ST_POWERUP: begin
                    d.cmd      = CMD_PRECHG;
                    d.addr[10] = 1'b1;
                    d.st       = ST_INIT_MODE;
                    d.cnt      = CNT_W'(TRP_CYC - 1);
                end
                ST_INIT_MODE: begin
                    d.cmd       = CMD_MODESET;
                    d.addr      = MODE_WORD;
                    d.st        = ST_INIT_REF;
                    d.cnt       = CNT_W'(TMRD_CYC - 1);
                    d.refs_left = RFW'(INIT_REFRESHES);
                end
                ST_INIT_REF: begin
                    d.cmd       = CMD_REFRESH;
                    d.cnt       = CNT_W'(TRC_CYC - 1);
                    d.refs_left = q.refs_left - 1'b1;
                    if (q.refs_left == RFW'(1)) begin
                        d.st        = ST_IDLE;
                        d.init_done = 1'b1;
                        d.dqm       = 1'b0;
                    end
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        d.cmd      = CMD_REFRESH;
                        d.cnt      = CNT_W'(TRC_CYC - 1);
                        ref_served = 1'b1;
                    end else if (req_valid) begin
                        d.cmd  = CMD_ACTIVE;
                        d.ba   = req_bank;
                        d.addr = req_row;
                        d.bank = req_bank;
                        d.col  = req_col;
                        d.wr   = req_write;
                        d.st   = ST_COLUMN;
                        d.cnt  = CNT_W'(TRCD_CYC - 1);
                    end
                end
                ST_COLUMN: begin
                    d.cmd              = q.wr ? CMD_WRITE : CMD_READ;
                    d.ba               = q.bank;
                    d.addr[COL_W-1:0]  = q.col;
                    d.ack              = 1'b1;
                    d.st               = ST_CLOSE;
                    d.cnt              = q.wr ? CNT_W'(WR_GAP - 1) : CNT_W'(RD_GAP - 1);
                end
                ST_CLOSE: begin
                    d.cmd = CMD_PRECHG;
                    d.ba  = q.bank;
                    d.st  = ST_IDLE;
                    d.cnt = CNT_W'(TRP_CYC - 1);
                end
                default: d.st = ST_POWERUP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_POWERUP;
            q.cnt       <= CNT_W'(INIT_CYC - 1);
            q.cmd       <= CMD_NOP;
            q.dqm       <= 1'b1;
        end else begin
            q <= d;
        end
    end

    sdr_cmd_pins u_pins (
        .cmd   (q.cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    assign req_ready = (q.st == ST_IDLE) && (q.cnt == '0) && !ref_pending;
    assign req_ack   = q.ack;
    assign sd_cke    = 1'b1;
    assign sd_ba     = q.ba;
    assign sd_addr   = q.addr;
    assign sd_dqm    = q.dqm;
endmodule

// File: rtl/sdr_ctl_checker.sv
module sdr_ctl_checker #(
    parameter int TRP_CYC  = 5,
    parameter int TRCD_CYC = 5,
    parameter int TRAS_CYC = 12,
    parameter int TRC_CYC  = 17,
    parameter int TMRD_CYC = 2,
    parameter int ROW_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             sd_dqm,
    input logic             req_ready,
    input logic             req_ack
);
    logic [3:0]  pin_cmd;
    logic        is_col;
    logic [15:0] since_mode, since_ref, since_act, since_pre;

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_col  = (pin_cmd == 4'b0101) || (pin_cmd == 4'b0100);

    function automatic logic [15:0] bump(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_mode <= 16'hFFFF;
            since_ref  <= 16'hFFFF;
            since_act  <= 16'hFFFF;
            since_pre  <= 16'hFFFF;
        end else begin
            since_mode <= (pin_cmd == 4'b0000) ? 16'd1 : bump(since_mode);
            since_ref  <= (pin_cmd == 4'b0001) ? 16'd1 : bump(since_ref);
            since_act  <= (pin_cmd == 4'b0011) ? 16'd1 : bump(since_act);
            since_pre  <= (pin_cmd == 4'b0010) ? 16'd1 : bump(since_pre);
        end
    end

    AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != 4'b0111) |-> (since_mode >= 16'(TMRD_CYC))); // R4
    AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != 4'b0111) |-> (since_ref >= 16'(TRC_CYC))); // R10
    AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act >= 16'(TRCD_CYC))); // R6
    AST_RAS_MET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_cmd == 4'b0010) && !sd_addr[10]) |-> (since_act >= 16'(TRAS_CYC))); // R8
    AST_RP_MET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_cmd == 4'b0011) || (pin_cmd == 4'b0001) || (pin_cmd == 4'b0000))
        |-> (since_pre >= 16'(TRP_CYC))); // R9
    AST_ACK_ON_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> is_col); // R7
    AST_COLUMN_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> req_ack); // R7
    AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sd_dqm); // R5
endmodule

bind sdr_init_refresh_ctl sdr_ctl_checker #(
    .TRP_CYC  (TRP_CYC),
    .TRCD_CYC (TRCD_CYC),
    .TRAS_CYC (TRAS_CYC),
    .TRC_CYC  (TRC_CYC),
    .TMRD_CYC (TMRD_CYC),
    .ROW_W    (ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm),
    .req_ready (req_ready),
    .req_ack   (req_ack)
);

// File: tb/sdr_init_refresh_ctl_test.sv
`timescale 1ns/1ps
module sdr_init_refresh_ctl_test;
    localparam int CLK_PS = 4000;
    localparam int T_INIT = 400_000;
    localparam int T_REFI = 240_000;
    localparam int TDPL   = 9;
    localparam int CL     = 3;
    localparam int E_INIT = (T_INIT + CLK_PS - 1) / CLK_PS;
    localparam int E_RP   = (20_000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RCD  = (20_000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RAS  = (45_000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RC   = (67_500 + CLK_PS - 1) / CLK_PS;
    localparam int E_REFI = T_REFI / CLK_PS;
    localparam int E_MRD  = 2;
    localparam int RD_GAP = (E_RAS - E_RCD > 1) ? E_RAS - E_RCD : 1;
    localparam int WR_GAP = (E_RAS - E_RCD > TDPL) ? E_RAS - E_RCD : TDPL;
    localparam int NREQ   = 16;
    localparam int LOGN   = 256;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MODE = 4'b0000;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_bank = 0;
    logic [11:0] req_row = 0;
    logic [8:0] req_col = 0;
    logic req_ready, req_ack, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
    logic [1:0] sd_ba;
    logic [11:0] sd_addr;

    sdr_init_refresh_ctl #(
        .CLK_PS(CLK_PS), .T_INIT_PS(T_INIT), .T_REFI_PS(T_REFI),
        .TDPL_CYC(TDPL), .CAS_LATENCY(CL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .req_ack(req_ack), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm)
    );

    always #2 clk = ~clk;

    int cyc = 0, checks = 0, errors = 0, n_log = 0, ack_stray = 0, r1_bad = 0;
    bit done = 0;
    int          lg_cyc  [0:LOGN-1];
    logic [3:0]  lg_cmd  [0:LOGN-1];
    logic [1:0]  lg_ba   [0:LOGN-1];
    logic [11:0] lg_addr [0:LOGN-1];
    logic        lg_ack  [0:LOGN-1];
    logic [1:0]  q_bank [0:NREQ-1];
    logic [11:0] q_row  [0:NREQ-1];
    logic [8:0]  q_col  [0:NREQ-1];
    logic        q_wr   [0:NREQ-1];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] c;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (req_ack != (c == C_RD || c == C_WR)) ack_stray++;
            if (!sd_cke) r1_bad++;
            if (n_log == 0 && (c != C_NOP || !sd_dqm || req_ready)) begin
                if (c == C_NOP) r1_bad++;
            end
            if (c != C_NOP && n_log < LOGN) begin
                lg_cyc[n_log] = cyc; lg_cmd[n_log] = c; lg_ba[n_log] = sd_ba;
                lg_addr[n_log] = sd_addr; lg_ack[n_log] = req_ack;
                n_log++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, p, r, kref, due_base, prev_cyc, expc, gap;
        logic [3:0] prev_cmd;
        for (int i = 0; i < NREQ; i++) begin
            q_bank[i] = 2'(i % 4);
            q_wr[i]   = ((i / 4) % 2) != 0;
            q_row[i]  = (i == 15) ? 12'hFFF : 12'((i * 613 + 29) % 4096);
            q_col[i]  = (i == 15) ? 9'h1FF : (i == 0) ? 9'h000 : 9'((i * 97 + 3) % 512);
        end
        repeat (3) @(negedge clk);
        // R1: reset state at the pins
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && sd_cke && sd_dqm && !req_ready,
            "R1 reset pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        rst_n = 1; c0 = cyc;
        while (n_log < 4) @(negedge clk);
        repeat (3 * E_REFI + 20) @(negedge clk);
        for (int i = 0; i < NREQ; i++) begin
            req_bank = q_bank[i]; req_row = q_row[i]; req_col = q_col[i];
            req_write = q_wr[i]; req_valid = 1;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
        end
        req_valid = 0;
        repeat (150) @(negedge clk);

        chk(lg_cmd[0] == C_PRE && lg_addr[0][10], "R2 first command precharge-all", lg_cmd[0], C_PRE);
        chk(lg_cyc[0] - c0 == E_INIT, "R2 power-up pause", lg_cyc[0] - c0, E_INIT);
        chk(lg_cmd[1] == C_MODE, "R3 mode set command", lg_cmd[1], C_MODE);
        chk(lg_cyc[1] - lg_cyc[0] == E_RP, "R3 spacing after precharge", lg_cyc[1] - lg_cyc[0], E_RP);
        chk(lg_addr[1] == 12'(CL << 4) && lg_ba[1] == 0, "R3 mode word", lg_addr[1], CL << 4);
        chk(lg_cmd[2] == C_REF && lg_cyc[2] - lg_cyc[1] == E_MRD, "R4 first refresh after mode set",
            lg_cyc[2] - lg_cyc[1], E_MRD);
        chk(lg_cmd[3] == C_REF && lg_cyc[3] - lg_cyc[2] == E_RC, "R5 init refresh spacing",
            lg_cyc[3] - lg_cyc[2], E_RC);
        chk(lg_cmd[4] == C_REF && lg_cyc[4] - lg_cyc[3] >= E_RC, "R10 first periodic refresh",
            lg_cyc[4] - lg_cyc[3], E_RC);
        for (int j = 5; j < 7; j++)
            chk(lg_cmd[j] == C_REF && lg_cyc[j] - lg_cyc[j-1] == E_REFI, "R10 idle refresh interval",
                lg_cyc[j] - lg_cyc[j-1], E_REFI);

        due_base = lg_cyc[4]; kref = 3; p = 7; r = 0;
        prev_cmd = C_REF; prev_cyc = lg_cyc[6];
        while (p < n_log) begin
            if (lg_cmd[p] == C_ACT && p + 2 < n_log && r < NREQ) begin
                gap = (prev_cmd == C_PRE) ? E_RP : E_RC;
                chk(lg_cyc[p] - prev_cyc >= gap, "R9 activate after precharge or refresh",
                    lg_cyc[p] - prev_cyc, gap);
                chk(lg_cyc[p] < due_base + kref * E_REFI, "R11 no activate once refresh due",
                    lg_cyc[p], due_base + kref * E_REFI);
                chk(lg_ba[p] == q_bank[r] && lg_addr[p] == q_row[r], "R6 activate bank and row",
                    lg_addr[p], q_row[r]);
                chk(lg_cmd[p+1] == (q_wr[r] ? C_WR : C_RD) && lg_cyc[p+1] - lg_cyc[p] == E_RCD,
                    "R6 column command after tRCD", lg_cyc[p+1] - lg_cyc[p], E_RCD);
                chk(lg_ba[p+1] == q_bank[r] && lg_addr[p+1] == {3'b000, q_col[r]},
                    "R6 column address", lg_addr[p+1], q_col[r]);
                chk(lg_ack[p+1] == 1'b1, "R7 ack with column command", lg_ack[p+1], 1);
                expc = q_wr[r] ? WR_GAP : RD_GAP;
                chk(lg_cmd[p+2] == C_PRE && lg_cyc[p+2] - lg_cyc[p+1] == expc,
                    "R8 close spacing", lg_cyc[p+2] - lg_cyc[p+1], expc);
                chk(!lg_addr[p+2][10] && lg_ba[p+2] == q_bank[r], "R8 single-bank close",
                    lg_addr[p+2], 0);
                prev_cmd = C_PRE; prev_cyc = lg_cyc[p+2]; p += 3; r++;
            end else if (lg_cmd[p] == C_REF) begin
                expc = prev_cyc + ((prev_cmd == C_PRE) ? E_RP : E_RC);
                if (due_base + kref * E_REFI > expc) expc = due_base + kref * E_REFI;
                chk(lg_cyc[p] == expc, "R11 refresh timing under load", lg_cyc[p], expc);
                kref++; prev_cmd = C_REF; prev_cyc = lg_cyc[p]; p++;
            end else begin
                chk(0, "R6 unexpected command", lg_cmd[p], C_ACT);
                p++;
            end
        end
        chk(r == NREQ, "R6 all requests served", r, NREQ);
        chk(kref > 5, "R11 refreshes interleaved with traffic", kref, 6);
        chk(ack_stray == 0, "R7 ack only with column command", ack_stray, 0);
        chk(r1_bad == 0, "R1 power-up pins and clock enable", r1_bad, 0);
        chk(!sd_dqm, "R5 data mask released after init", sd_dqm, 0);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule